// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Arbiter

This block decides when a DRAM array gets refreshed and keeps refresh out of the way of normal memory accesses. A free-running timer, whose period is chosen by a 4-bit field, raises an internal refresh request at regular intervals. A separate external request input can ask for a refresh at any time. A pending request waits for the access controller to drop its access-active line and for a programmable number of precharge clocks to pass. After that, the block takes the array for one refresh cycle.

A refresh cycle starts with one lead clock in which the busy flag is already high and every RAS strobe is still high. Then the four active-low RAS strobes go low, either together or one clock apart in staggered mode. Each stays low for a programmed number of clocks, and an extend input can stretch this by whole clocks. After the last strobe has returned high, a 10-bit row address counter advances by one. While a request is pending or a refresh is running, a hold output tells the access controller not to start a new access. An access that is already running is never cut short. Refresh can still be slotted into a single idle clock between two pipelined accesses.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While `refresh_disable` is low, the internal timer raises a request every (`cfg_period`+1)×`TICK_DIV` clocks (8 by default). So successive rising edges of `refresh_hold` are exactly that far apart when no access gets in the way.
- R2: A pending refresh starts only when `acc_active` is low and at least `PRE_GAP` access-free clocks have gone by (default 0). `refresh_busy` rises on the clock after the first clock that meets both conditions, so with `PRE_GAP`=0 it rises one clock after `acc_active` falls.
- R3: While `acc_active` is high, `refresh_busy` never rises. A request that is pending when an access ends is served in a single idle clock between two accesses.
- R4: While `refresh_disable` is high, no internal request is raised and any pending internal request is dropped. When the input is released, the timer starts a full period from zero.
- R5: `refresh_busy` is high for exactly one clock with all of `ras_n` high before the first refresh RAS falls. Outside a refresh cycle, `ras_n` is all ones.
- R6: Each RAS strobe stays low for `cfg_ras_len`+2 clocks (2 to 5). The length and the mode are captured when the refresh starts.
- R7: Every clock in which `stretch` is high while the strobes are sequencing holds the current `ras_n` pattern for one more clock. It therefore lengthens the refresh by whole clocks.
- R8: `row_addr` starts at 0 after reset. It goes up by one, modulo 1024, once per refresh. The new value appears one clock after the first clock in which all strobes are high again at the end of the refresh.
- R9: With `cfg_stagger` low, all four strobes fall and rise on the same clocks (`ras_n` is 4'b0000 or 4'b1111).
- R10: With `cfg_stagger` high, `ras_n[i]` falls i clocks after `ras_n[0]`. The refresh then lasts `cfg_ras_len`+2+3 sequencing clocks.
- R11: `refresh_hold` is high from the clock after a request is latched until `refresh_busy` falls at the end of the refresh it triggers. A request that arrives during a refresh keeps it high afterwards.
- R12: A one-clock pulse on `ext_refresh_req` triggers a refresh through the same arbitration path as the timer, and it does so even while `refresh_disable` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_period | input | 4 | Timer period select, period = (value+1)×TICK_DIV clocks |
| cfg_ras_len | input | 2 | RAS low time select, value+2 clocks |
| cfg_stagger | input | 1 | 1: strobes fall one clock apart; 0: all together |
| refresh_disable | input | 1 | Stops the internal timer and drops its pending request |
| ext_refresh_req | input | 1 | External refresh request, one-clock pulse |
| stretch | input | 1 | Holds the strobe sequence for one clock per high clock |
| acc_active | input | 1 | An access controller has an access in progress |
| ras_n | output | 4 | Active-low refresh RAS strobes |
| refresh_busy | output | 1 | Refresh in progress, high one clock before first RAS |
| refresh_hold | output | 1 | Refresh pending or running; no new access may start |
| row_addr | output | 10 | Refresh row address counter |

## Verification
The hardest case to reach is a pending timer request meeting a single idle clock between two pipelined accesses. In that case the request must win the gap, and `refresh_busy` must not rise while the second access is already asserted. The bench holds `acc_active` high for longer than a timer period with the shortest period, so a request is sure to be pending. It then drops `acc_active` for one clock and raises it again only after the refresh finishes. A behavioural model, which counts timer clocks and refresh steps with plain integers, predicts every output on every clock. The stretch pulses and the 1030-refresh row wrap are driven the same way.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } rfsh_state_e;

  // Minimum number of clocks a refresh strobe is held low
  localparam int RAS_MIN_CLKS = 2;
endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int PER_W    = 4,
  parameter int TICK_DIV = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] per_sel,
  input  logic             tmr_off,
  output logic             tick
);
  localparam int LIM_MAX = (1 << PER_W) * TICK_DIV;
  localparam int CNT_W   = $clog2(LIM_MAX + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'((int'(per_sel) + 1) * TICK_DIV - 1);
  assign tick  = !tmr_off && (cnt_q >= limit);

  always_comb begin
    if (tmr_off || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Two requests are never one clock apart (period is at least TICK_DIV)
  p_tick_spaced_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/rfsh_arbiter.sv
module rfsh_arbiter
  import rfsh_pkg::*;
#(
  parameter int PRE_GAP = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        int_off,
  input  logic        ext_req,
  input  logic        acc_active,
  input  logic        seq_last,
  output rfsh_state_e state,
  output logic        start,
  output logic        busy,
  output logic        hold
);
  localparam int GAP_W = $clog2(PRE_GAP + 2);

  rfsh_state_e      state_q, state_d;
  logic             ipend_q, ipend_d;
  logic             epend_q, epend_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             gap_ok;

  assign gap_ok = (gap_q == GAP_W'(PRE_GAP));
  assign start  = (state_q == ST_IDLE) && (ipend_q || epend_q) && !acc_active && gap_ok;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start)    state_d = ST_ARM;
      ST_ARM:                state_d = ST_RUN;
      ST_RUN:  if (seq_last) state_d = ST_DONE;
      ST_DONE:               state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ipend_d = !int_off && ((ipend_q && !start) || tick);
    epend_d = (epend_q && !start) || ext_req;
    if (acc_active || (state_q == ST_RUN)) gap_d = '0;
    else if (gap_ok)                       gap_d = gap_q;
    else                                   gap_d = gap_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ipend_q <= 1'b0;
      epend_q <= 1'b0;
      gap_q   <= GAP_W'(PRE_GAP);
    end else begin
      state_q <= state_d;
      ipend_q <= ipend_d;
      epend_q <= epend_d;
      gap_q   <= gap_d;
    end
  end

  assign state = state_q;
  assign busy  = (state_q != ST_IDLE);
  assign hold  = ipend_q || epend_q || busy;

  p_no_start_on_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(acc_active));

  p_off_drops_request_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int_off |=> !ipend_q);

  p_lead_one_clock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARM) |=> (state_q == ST_RUN));
endmodule

// File: rtl/ras_seq.sv
module ras_seq
  import rfsh_pkg::*;
#(
  parameter int N_RAS = 4,
  parameter int LEN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic             stretch,
  input  logic [LEN_W-1:0] len_cfg,
  input  logic             stag_cfg,
  output logic             last,
  output logic [N_RAS-1:0] ras_n
);
  localparam int MAX_SPAN = (1 << LEN_W) - 1 + RAS_MIN_CLKS + N_RAS - 1;
  localparam int STEP_W   = $clog2(MAX_SPAN + 1);

  logic [LEN_W-1:0]  len_q;
  logic              stag_q;
  logic [STEP_W-1:0] step_q, step_d;
  logic [STEP_W-1:0] low_len;
  logic [STEP_W-1:0] span;

  assign low_len = STEP_W'(len_q) + STEP_W'(RAS_MIN_CLKS);
  assign span    = low_len + (stag_q ? STEP_W'(N_RAS - 1) : '0);
  assign last    = run && !stretch && (step_q == span - 1'b1);

  always_comb begin
    if (!run)         step_d = '0;
    else if (stretch) step_d = step_q;
    else              step_d = step_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      stag_q <= 1'b0;
      step_q <= '0;
    end else begin
      if (load) begin
        len_q  <= len_cfg;
        stag_q <= stag_cfg;
      end
      step_q <= step_d;
    end
  end

  for (genvar i = 0; i < N_RAS; i++) begin : g_ras
    if (i == 0) begin : g_first
      assign ras_n[i] = !(run && (step_q < low_len));
    end else begin : g_rest
      logic [STEP_W-1:0] rel;
      logic              low_now;
      assign rel     = step_q - STEP_W'(i);
      assign low_now = stag_q ? ((step_q >= STEP_W'(i)) && (rel < low_len))
                              : (step_q < low_len);
      assign ras_n[i] = !(run && low_now);

      p_stagger_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stag_q && $fell(ras_n[i])) |-> !$past(ras_n[i-1]));
    end
  end

  p_lockstep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !stag_q |-> ((ras_n == '0) || (ras_n == '1)));

  p_stretch_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && stretch) |=> $stable(ras_n));
endmodule

// File: rtl/row_ctr.sv
module row_ctr #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [ROW_W-1:0] row
);
  logic [ROW_W-1:0] row_q;
  logic [ROW_W-1:0] row_d;

  always_comb row_d = inc ? (row_q + 1'b1) : row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else        row_q <= row_d;
  end

  assign row = row_q;

  p_row_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (row_q != $past(row_q)) |-> (row_q == $past(row_q) + 1'b1));
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import rfsh_pkg::*;
#(
  parameter int PER_W    = 4,
  parameter int LEN_W    = 2,
  parameter int N_RAS    = 4,
  parameter int ROW_W    = 10,
  parameter int TICK_DIV = 8,
  parameter int PRE_GAP  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] cfg_period,
  input  logic [LEN_W-1:0] cfg_ras_len,
  input  logic             cfg_stagger,
  input  logic             refresh_disable,
  input  logic             ext_refresh_req,
  input  logic             stretch,
  input  logic             acc_active,
  output logic [N_RAS-1:0] ras_n,
  output logic             refresh_busy,
  output logic             refresh_hold,
  output logic [ROW_W-1:0] row_addr
);
  logic        rst_meta, rst_int;
  logic        tick, start, busy, hold, seq_last;
  rfsh_state_e state;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_int  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_int  <= rst_meta;
    end
  end

  rfsh_timer #(.PER_W(PER_W), .TICK_DIV(TICK_DIV)) u_timer (
    .clk     (clk),
    .rst_n   (rst_int),
    .per_sel (cfg_period),
    .tmr_off (refresh_disable),
    .tick    (tick)
  );

  rfsh_arbiter #(.PRE_GAP(PRE_GAP)) u_arb (
    .clk        (clk),
    .rst_n      (rst_int),
    .tick       (tick),
    .int_off    (refresh_disable),
    .ext_req    (ext_refresh_req),
    .acc_active (acc_active),
    .seq_last   (seq_last),
    .state      (state),
    .start      (start),
    .busy       (busy),
    .hold       (hold)
  );

  ras_seq #(.N_RAS(N_RAS), .LEN_W(LEN_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_int),
    .load     (start),
    .run      (state == ST_RUN),
    .stretch  (stretch),
    .len_cfg  (cfg_ras_len),
    .stag_cfg (cfg_stagger),
    .last     (seq_last),
    .ras_n    (ras_n)
  );

  row_ctr #(.ROW_W(ROW_W)) u_row (
    .clk   (clk),
    .rst_n (rst_int),
    .inc   (state == ST_DONE),
    .row   (row_addr)
  );

  assign refresh_busy = busy;
  assign refresh_hold = hold;

  p_busy_leads_ras_r5: assert property (@(posedge clk) disable iff (!rst_int)
    ((ras_n != '1) && ($past(ras_n) == '1)) |-> $past(refresh_busy));

  p_ras_needs_busy_r5: assert property (@(posedge clk) disable iff (!rst_int)
    (ras_n != '1) |-> refresh_busy);

  p_row_after_release_r8: assert property (@(posedge clk) disable iff (!rst_int)
    (row_addr != $past(row_addr)) |-> (($past(ras_n) == '1) && (ras_n == '1)));

  p_hold_covers_busy_r11: assert property (@(posedge clk) disable iff (!rst_int)
    $fell(refresh_hold) |-> $fell(refresh_busy) || !$past(refresh_busy));
endmodule

// File: tb/tb_dram_refresh_ctrl.sv
`timescale 1ns/1ps
module tb_dram_refresh_ctrl;
  localparam int PER_W = 4, LEN_W = 2, N_RAS = 4, ROW_W = 10;
  localparam int TICK_DIV = 8, PRE_GAP = 0;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n;
  logic [PER_W-1:0] cfg_period;
  logic [LEN_W-1:0] cfg_ras_len;
  logic             cfg_stagger, refresh_disable, ext_refresh_req, stretch, acc_active;
  logic [N_RAS-1:0] ras_n;
  logic             refresh_busy, refresh_hold;
  logic [ROW_W-1:0] row_addr;

  dram_refresh_ctrl #(.PER_W(PER_W), .LEN_W(LEN_W), .N_RAS(N_RAS), .ROW_W(ROW_W),
                      .TICK_DIV(TICK_DIV), .PRE_GAP(PRE_GAP)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_ras_len(cfg_ras_len),
    .cfg_stagger(cfg_stagger), .refresh_disable(refresh_disable),
    .ext_refresh_req(ext_refresh_req), .stretch(stretch), .acc_active(acc_active),
    .ras_n(ras_n), .refresh_busy(refresh_busy), .refresh_hold(refresh_hold),
    .row_addr(row_addr));

  int n_chk = 0, n_bad = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  int m_tmr, m_ph, m_step, m_gap, m_row, m_len, m_stag;
  bit m_ip, m_ep;

  always @(posedge clk or negedge rst_n) begin : mdl
    int per, span;
    bit fire, strt;
    if (!rst_n) begin
      m_tmr = 0; m_ph = 0; m_step = 0; m_gap = PRE_GAP; m_row = 0;
      m_len = 2; m_stag = 0; m_ip = 0; m_ep = 0;
    end else begin
      per  = (int'(cfg_period) + 1) * TICK_DIV;
      fire = !refresh_disable && (m_tmr >= per - 1);
      strt = (m_ph == 0) && (m_ip || m_ep) && !acc_active && (m_gap >= PRE_GAP);
      m_gap = (acc_active || m_ph == 2) ? 0 : ((m_gap < PRE_GAP) ? m_gap + 1 : PRE_GAP);
      m_tmr = (refresh_disable || fire) ? 0 : m_tmr + 1;
      m_ip  = !refresh_disable && ((m_ip && !strt) || fire);
      m_ep  = (m_ep && !strt) || ext_refresh_req;
      case (m_ph)
        0: if (strt) begin
             m_ph = 1; m_len = int'(cfg_ras_len) + 2; m_stag = cfg_stagger ? 1 : 0;
           end
        1: begin m_ph = 2; m_step = 0; end
        2: begin
             span = m_len + (m_stag ? N_RAS - 1 : 0);
             if (!stretch) begin
               if (m_step == span - 1) m_ph = 3;
               else m_step = m_step + 1;
             end
           end
        default: begin m_ph = 0; m_row = (m_row + 1) % (1 << ROW_W); end
      endcase
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin : cmp
    logic [N_RAS-1:0] exp_ras;
    if (rst_n) begin
      for (int i = 0; i < N_RAS; i++) begin
        int lo;
        lo = m_stag * i;
        exp_ras[i] = !((m_ph == 2) && (m_step >= lo) && (m_step < lo + m_len));
      end
      chk(ras_n == exp_ras, "R6 R9 R10 ras strobes", int'(ras_n), int'(exp_ras));
      chk(refresh_busy == (m_ph != 0), "R5 R2 busy", int'(refresh_busy), int'(m_ph != 0));
      chk(refresh_hold == (m_ip || m_ep || m_ph != 0), "R11 hold",
          int'(refresh_hold), int'(m_ip || m_ep || m_ph != 0));
      chk(int'(row_addr) == m_row, "R8 row address", int'(row_addr), m_row);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 150000);
      finish_up();
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    do step(1); while (refresh_busy || refresh_hold);
  endtask

  task automatic pulse_ext();
    ext_refresh_req = 1'b1; step(1); ext_refresh_req = 1'b0;
  endtask

  initial begin
    int bc, r0, nr;
    int rise[3];
    bit prev;
    rst_n = 1'b0; cfg_period = '0; cfg_ras_len = '0; cfg_stagger = 1'b0;
    refresh_disable = 1'b1; ext_refresh_req = 1'b0; stretch = 1'b0; acc_active = 1'b0;
    step(3); rst_n = 1'b1; step(3);

    chk(ras_n == '1, "R5 reset strobes high", int'(ras_n), 15);
    chk(!refresh_busy, "R5 reset busy", int'(refresh_busy), 0);
    chk(!refresh_hold, "R11 reset hold", int'(refresh_hold), 0);
    chk(row_addr == '0, "R8 reset row", int'(row_addr), 0);

    // R12: external request accepted while internal refresh is disabled
    pulse_ext(); wait_idle();
    chk(row_addr == 10'd1, "R12 external refresh while disabled", int'(row_addr), 1);

    // R6 / R9: each low length in all-RAS mode
    for (int l = 1; l < 4; l++) begin
      cfg_ras_len = LEN_W'(l); pulse_ext(); wait_idle();
    end

    // R7 / R10: staggered, len 3, two stretch clocks -> 1+8+2+1 busy clocks
    cfg_ras_len = 2'd3; cfg_stagger = 1'b1; pulse_ext();
    while (!refresh_busy) step(1);
    bc = 0;
    while (refresh_busy) begin
      bc++;
      stretch = (bc == 4 || bc == 5);
      step(1);
    end
    stretch = 1'b0;
    chk(bc == 12, "R7 stretch adds whole clocks", bc, 12);
    cfg_ras_len = 2'd0; pulse_ext(); wait_idle();

    // R1: period (1+1)*8 = 16 clocks between requests
    cfg_stagger = 1'b0; cfg_ras_len = 2'd1; cfg_period = 4'd1; refresh_disable = 1'b0;
    prev = refresh_hold; nr = 0;
    for (int k = 0; k < 70; k++) begin
      step(1);
      if (refresh_hold && !prev && nr < 3) begin rise[nr] = k; nr++; end
      prev = refresh_hold;
    end
    chk(nr == 3, "R1 request count", nr, 3);
    chk(rise[1] - rise[0] == 16, "R1 timer period", rise[1] - rise[0], 16);
    chk(rise[2] - rise[1] == 16, "R1 timer period", rise[2] - rise[1], 16);
    refresh_disable = 1'b1; wait_idle();

    // R3 / R2 / R5: access blocks refresh, release lets it in one clock later
    cfg_period = 4'd0; refresh_disable = 1'b0; acc_active = 1'b1;
    for (int k = 0; k < 40; k++) begin
      step(1);
      chk(!refresh_busy, "R3 no refresh during access", int'(refresh_busy), 0);
    end
    acc_active = 1'b0; step(1);
    chk(refresh_busy, "R2 busy one clock after release", int'(refresh_busy), 1);
    chk(ras_n == '1, "R5 strobes high in lead clock", int'(ras_n), 15);
    step(1);
    chk(!ras_n[0], "R5 first strobe low after lead clock", int'(ras_n[0]), 0);
    while (refresh_busy) step(1);

    // R3: refresh slotted into a one-clock gap between pipelined accesses
    acc_active = 1'b1; step(10); acc_active = 1'b0; step(1);
    chk(refresh_busy, "R3 refresh inserted in gap", int'(refresh_busy), 1);
    while (refresh_busy) step(1);
    acc_active = 1'b1; step(10); acc_active = 1'b0; step(3);

    // R4: disable drops a pending internal request
    refresh_disable = 1'b1; wait_idle();
    cfg_period = 4'd15; refresh_disable = 1'b0; acc_active = 1'b1;
    for (int k = 0; k < 200 && !refresh_hold; k++) step(1);
    chk(refresh_hold, "R4 request pending before disable", int'(refresh_hold), 1);
    refresh_disable = 1'b1; step(1); acc_active = 1'b0;
    for (int k = 0; k < 20; k++) begin
      step(1);
      chk(!refresh_busy && !refresh_hold, "R4 disabled request dropped",
          int'(refresh_hold), 0);
    end

    // mixed traffic, compared clock by clock
    refresh_disable = 1'b0; cfg_period = 4'd0;
    for (int k = 0; k < 200; k++) begin
      stretch     = (k % 7 == 3);
      cfg_stagger = (k % 50 < 25);
      cfg_ras_len = LEN_W'(k % 4);
      acc_active  = (k % 13 < 4) && (acc_active || !refresh_busy);
      step(1);
    end
    stretch = 1'b0; acc_active = 1'b0;

    // R8: row counter wraps
    refresh_disable = 1'b1; cfg_stagger = 1'b0; cfg_ras_len = 2'd0; wait_idle();
    r0 = int'(row_addr);
    for (int k = 0; k < 1030; k++) begin
      pulse_ext(); wait_idle();
    end
    chk(int'(row_addr) == (r0 + 1030) % 1024, "R8 row wraps modulo 1024",
        int'(row_addr), (r0 + 1030) % 1024);
    step(4);
    finish_up();
  end
endmodule